// File: doc/BRIEF.md
# Run-Length Timestamped Sample Packer

The packer watches a sampled input word once per clock tick and turns the stream into compact records for a row-organised sample memory. A free-running timestamp counts ticks. Storage is change-driven: as long as the input keeps the value that was last stored, the packer writes nothing. When the input moves away from that value, the packer opens a cluster. A cluster is one timestamp word followed by seven event words, written to consecutive memory addresses on consecutive clocks. Event slot j holds the sample taken j ticks after the cluster's timestamp. When the input does not change inside the cluster, the slot holds a repeat of the previous sample, which serves as padding.

To keep the 16-bit timestamp unambiguous after it wraps, a cluster is forced when 65535 ticks have passed since the last cluster opened. A cluster is also forced on the first tick after reset or clear. The write position is a 24-bit word address: the upper 15 bits select a 512-word row and the lower 9 bits select the word within the row. A row holds exactly 64 clusters, and a pulse marks the write of the last word of each row. Cluster size (event count plus one) must be a power of two that divides the row length.

Top module: `rlp_packer`

## Requirements
- R1: With rst_n low or clr_i high at a clock edge, the following outputs are all zero: wr_en_o, row_full_o and pos_o. On the first tick after reset or clear, a cluster is forced. Its timestamp word is 0 and it is written at address 0.
- R2: A cluster is written as eight words on eight consecutive clocks to eight consecutive addresses. The first word is the timestamp, and the first word's address has its low 3 bits at 0.
- R3: The event word in slot j (j = 0..6) equals the input sampled at tick timestamp+j. A tick with no change is stored as a repeat of the previous sample.
- R4: While no cluster is being written, a tick whose sample equals the last stored event value causes no write.
- R5: While no cluster is being written, a tick whose sample differs from the last stored event value opens a cluster. The cluster's timestamp word is that tick's count, and the count is 0 on the first tick after reset or clear.
- R6: The tick on which the seventh event word is written is not compared. From the following tick onward, each sample is compared against the seventh event value.
- R7: If 65535 ticks pass after a cluster opens with no cluster opened in between, a cluster is forced on that tick. The timestamp counts modulo 65536.
- R8: pos_o is the address of the next write. Each write uses address pos_o and then advances it by one. pos_o keeps its value on clocks without a write.
- R9: row_full_o is high for exactly the clock on which word 511 of a row is written (address bits 8:0 all ones).
- R10: After the last word of the last row is written, the position wraps to address 0.
- R11: clr_i abandons a cluster that is partly written. It also resets the timestamp, the position and the last stored sample to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every rising edge is one sample tick |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of timestamp, position and last sample |
| smp_i | input | 16 | Sampled input word |
| wr_en_o | output | 1 | Memory write enable |
| wr_addr_o | output | 24 | Memory word address (row in bits 23:9, word in bits 8:0) |
| wr_data_o | output | 16 | Memory write data (timestamp or event word) |
| pos_o | output | 24 | Current write position (next address to be written) |
| row_full_o | output | 1 | Pulse with the write of the last word of a row |

## Verification
The forced cluster after 65535 quiet ticks is the hardest case to reach from the ports. The stimulus first opens a cluster, then holds the input constant for more than 65536 ticks, and checks that the forced cluster's timestamp has wrapped correctly. Row wrap needs the whole memory to be filled, so the bench builds the packer with four rows. It then toggles the input on every tick, which gives back-to-back clusters with no idle gap and crosses every row boundary. The blind tick is reached by changing the input exactly on the seventh event write, in two variants: one where the value stays changed and one where it returns to its old value.

// File: rtl/rlp_pkg.sv
// Shared types of the run-length packer.
// Assumes: nothing beyond IEEE 1800-2017.
package rlp_pkg;

    // Kind of word the packer emits on a given tick.
    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_STAMP = 2'd1,
        WK_EVENT = 2'd2
    } word_kind_t;

endpackage

// File: rtl/rlp_timebase.sv
// Tick counter and cluster-age tracker.
// Counts one tick per clock. Remembers the tick on which the last cluster
// opened and requests a forced cluster when the age reaches its maximum
// value, or on the first tick after reset/clear.
// Assumes: open_i is high for at most one tick per cluster.
module rlp_timebase #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            open_i,
    output logic [TS_W-1:0] ts_o,
    output logic            force_o
);

    logic [TS_W-1:0] ts_q;
    logic [TS_W-1:0] base_q;
    logic            pend_q;
    logic [TS_W-1:0] age;

    // Advance the tick count and record the opening tick of each cluster.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            ts_q   <= '0;
            base_q <= '0;
            pend_q <= 1'b1;
        end else begin
            ts_q <= ts_q + 1'b1;
            if (open_i) begin
                base_q <= ts_q;
                pend_q <= 1'b0;
            end
        end
    end

    // Age of the open cluster, modulo the counter width.
    always_comb begin
        age     = ts_q - base_q;
        force_o = pend_q || (age == {TS_W{1'b1}});
    end

    assign ts_o = ts_q;

endmodule

// File: rtl/rlp_cluster_ctl.sv
// Cluster sequencer.
// Decides on every tick whether a cluster opens, an event word is due, or
// nothing is written. It holds the sample that the next event word will
// carry and the last value committed to storage.
// Assumes: one word can be written per clock; a cluster spans EVT_N + 1 clocks.
module rlp_cluster_ctl #(
    parameter int DATA_W = 16,
    parameter int EVT_N  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] smp_i,
    input  logic              force_i,
    output logic              open_o,
    output logic              evt_o,
    output logic [DATA_W-1:0] hold_o
);

    localparam int CW = $clog2(EVT_N + 1);

    logic [CW-1:0]     cnt_q;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] last_q;
    logic              idle;

    // Open on a change or a force request, but only between clusters.
    always_comb begin
        idle   = (cnt_q == '0);
        open_o = idle && (force_i || (smp_i != last_q));
        evt_o  = !idle;
    end

    // Step through the event slots and capture the sample for the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q  <= '0;
            hold_q <= '0;
            last_q <= '0;
        end else if (open_o) begin
            cnt_q  <= CW'(1);
            hold_q <= smp_i;
            last_q <= smp_i;
        end else if (!idle) begin
            if (cnt_q == CW'(EVT_N)) begin
                cnt_q <= '0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                hold_q <= smp_i;
                last_q <= smp_i;
            end
        end
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/rlp_addr_gen.sv
// Write position generator.
// Keeps the next word address as {row, word} and advances it by one per
// write, wrapping at the top of the address space. Flags the last word of
// a row.
// Assumes: adv_i is high only when a word is written at pos_o.
module rlp_addr_gen #(
    parameter int WORD_BITS = 9,
    parameter int ROW_BITS  = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          adv_i,
    output logic [ROW_BITS+WORD_BITS-1:0] pos_o,
    output logic                          row_end_o
);

    localparam int AW = ROW_BITS + WORD_BITS;

    logic [AW-1:0] pos_q;

    // Move to the next word after every write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pos_q <= '0;
        end else if (adv_i) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // Last word of the current row.
    always_comb begin
        row_end_o = &pos_q[WORD_BITS-1:0];
    end

    assign pos_o = pos_q;

endmodule

// File: rtl/rlp_packer.sv
// Run-length timestamped sample packer, top level.
// Combines the tick counter, the cluster sequencer and the position
// generator, and registers the memory write port.
// Assumes: one sample tick per clock; the memory accepts one word per clock;
// EVT_N + 1 is a power of two that divides 2**WORD_BITS.
module rlp_packer #(
    parameter int DATA_W    = 16,
    parameter int EVT_N     = 7,
    parameter int WORD_BITS = 9,
    parameter int ROW_BITS  = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic [DATA_W-1:0]             smp_i,
    output logic                          wr_en_o,
    output logic [ROW_BITS+WORD_BITS-1:0] wr_addr_o,
    output logic [DATA_W-1:0]             wr_data_o,
    output logic [ROW_BITS+WORD_BITS-1:0] pos_o,
    output logic                          row_full_o
);

    import rlp_pkg::*;

    localparam int AW = ROW_BITS + WORD_BITS;

    logic [DATA_W-1:0] ts;
    logic              force_req;
    logic              open_c;
    logic              evt_c;
    logic [DATA_W-1:0] hold;
    logic [AW-1:0]     pos;
    logic              row_end;
    logic              write_c;
    word_kind_t        kind;

    rlp_timebase #(
        .TS_W (DATA_W)
    ) tb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .open_i  (open_c),
        .ts_o    (ts),
        .force_o (force_req)
    );

    rlp_cluster_ctl #(
        .DATA_W (DATA_W),
        .EVT_N  (EVT_N)
    ) ctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .smp_i   (smp_i),
        .force_i (force_req),
        .open_o  (open_c),
        .evt_o   (evt_c),
        .hold_o  (hold)
    );

    rlp_addr_gen #(
        .WORD_BITS (WORD_BITS),
        .ROW_BITS  (ROW_BITS)
    ) ag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_i),
        .adv_i     (write_c),
        .pos_o     (pos),
        .row_end_o (row_end)
    );

    // Classify this tick's word.
    always_comb begin
        if (open_c)      kind = WK_STAMP;
        else if (evt_c)  kind = WK_EVENT;
        else             kind = WK_IDLE;
        write_c = (kind != WK_IDLE);
    end

    // Register the memory write port and the row-end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wr_en_o    <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
            row_full_o <= 1'b0;
        end else begin
            wr_en_o    <= write_c;
            row_full_o <= write_c && row_end;
            if (write_c) begin
                wr_addr_o <= pos;
                wr_data_o <= (kind == WK_STAMP) ? ts : hold;
            end
        end
    end

    assign pos_o = pos;

endmodule

// File: rtl/rlp_packer_chk.sv
// Port-level checker for the packer, bound into every instance.
// Assumes: synchronous active-low reset held low at time zero.
module rlp_packer_chk #(
    parameter int EVT_N     = 7,
    parameter int WORD_BITS = 9,
    parameter int ROW_BITS  = 15
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          clr_i,
    input logic                          wr_en_o,
    input logic [ROW_BITS+WORD_BITS-1:0] wr_addr_o,
    input logic [ROW_BITS+WORD_BITS-1:0] pos_o,
    input logic                          row_full_o
);

    localparam int AW = ROW_BITS + WORD_BITS;
    localparam int CB = $clog2(EVT_N + 1);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) || $past(clr_i)) |-> (!wr_en_o && !row_full_o && pos_o == '0));

    // R8
    pos_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (pos_o == AW'(wr_addr_o + 1'b1)));

    // R8
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_o && $past(rst_n) && !$past(clr_i)) |-> $stable(pos_o));

    // R2
    cluster_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clr_i && wr_en_o && (wr_addr_o[CB-1:0] != {CB{1'b1}}))
        |=> (wr_en_o && wr_addr_o == AW'($past(wr_addr_o) + 1'b1)));

    // R2
    cluster_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !$past(wr_en_o) && $past(rst_n)) |-> (wr_addr_o[CB-1:0] == '0));

    // R9
    row_full_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_full_o |-> (wr_en_o && (&wr_addr_o[WORD_BITS-1:0])));

endmodule

bind rlp_packer rlp_packer_chk #(
    .EVT_N     (EVT_N),
    .WORD_BITS (WORD_BITS),
    .ROW_BITS  (ROW_BITS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .pos_o      (pos_o),
    .row_full_o (row_full_o)
);

// File: tb/rlp_packer_tb_top.sv
// Scoreboard bench: the driver computes the expected write of every tick
// from the requirements and queues it; the monitor compares after each edge.
module rlp_packer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int WB = 9;
    localparam int RB = 2;
    localparam int AW = WB + RB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_i = 1'b0;
    logic [DW-1:0] smp_i = '0;
    logic          wr_en_o;
    logic [AW-1:0] wr_addr_o;
    logic [DW-1:0] wr_data_o;
    logic [AW-1:0] pos_o;
    logic          row_full_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur = "R1";

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          rf;
        logic [AW-1:0] pos;
        string         tag;
    } exp_t;

    exp_t q[$];

    // Reference state, derived from the requirements.
    logic [DW-1:0] m_ts, m_clts, m_last, m_hold;
    logic [AW-1:0] m_pos;
    int            m_cnt;
    bit            m_force;

    always #(CLK_PERIOD/2) clk = ~clk;

    rlp_packer #(
        .DATA_W    (DW),
        .EVT_N     (7),
        .WORD_BITS (WB),
        .ROW_BITS  (RB)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .smp_i      (smp_i),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .pos_o      (pos_o),
        .row_full_o (row_full_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Driver: apply one tick and queue what the memory port must show after it.
    task automatic step(logic [DW-1:0] s, bit clr = 0, bit rst = 0);
        exp_t e;
        @(negedge clk);
        smp_i = s;
        clr_i = clr;
        rst_n = !rst;
        e.we = 0; e.addr = '0; e.data = '0; e.rf = 0; e.tag = cur;
        if (rst || clr) begin
            m_ts = '0; m_clts = '0; m_last = '0; m_hold = '0;
            m_pos = '0; m_cnt = 0; m_force = 1;
        end else begin
            if (m_cnt == 0) begin
                if (m_force || s != m_last || (DW'(m_ts - m_clts) == {DW{1'b1}})) begin
                    e.we = 1; e.data = m_ts; e.addr = m_pos;
                    m_hold = s; m_last = s; m_cnt = 1; m_clts = m_ts; m_force = 0;
                end
            end else begin
                e.we = 1; e.data = m_hold; e.addr = m_pos;
                if (m_cnt < 7) begin
                    m_hold = s; m_last = s; m_cnt++;
                end else begin
                    m_cnt = 0;
                end
            end
            if (e.we) begin
                e.rf = &e.addr[WB-1:0];
                m_pos = m_pos + 1'b1;
            end
            m_ts = m_ts + 1'b1;
        end
        e.pos = m_pos;
        q.push_back(e);
    endtask

    // Monitor: compare each edge's result against the oldest queued item.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(e.tag, "wr_en", wr_en_o, e.we);
                chk("R8", "pos", pos_o, e.pos);
                chk("R9", "row_full", row_full_o, e.rf);
                if (e.we) begin
                    chk("R8", "wr_addr", wr_addr_o, e.addr);
                    chk(e.tag, "wr_data", wr_data_o, e.data);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset, then forced first cluster at address 0 with timestamp 0.
        cur = "R1";
        for (int i = 0; i < 3; i++) step(16'h0000, 0, 1);
        for (int i = 0; i < 8; i++) step(16'h0000);
        // R4: steady input writes nothing.
        cur = "R4";
        for (int i = 0; i < 10; i++) step(16'h0000);
        // R5: a change opens a cluster stamped with its tick.
        cur = "R5";
        step(16'hA5A5);
        // R3 / R2: varied event slots, with repeats as padding.
        cur = "R3";
        step(16'h1234); step(16'h1234); step(16'hFFFF);
        step(16'h0000); step(16'h0000); step(16'h0007);
        cur = "R2";
        step(16'h0007);
        cur = "R4";
        for (int i = 0; i < 6; i++) step(16'h0007);
        // R6: change on the blind tick that persists opens a cluster next tick.
        cur = "R6";
        step(16'h0100);
        for (int i = 0; i < 6; i++) step(16'h0100);
        step(16'h0200);
        step(16'h0200);
        for (int i = 0; i < 9; i++) step(16'h0200);
        // R6: change on the blind tick that returns is never stored.
        step(16'h0300);
        for (int i = 0; i < 6; i++) step(16'h0300);
        step(16'h0400);
        for (int i = 0; i < 6; i++) step(16'h0300);
        // R11: clear in the middle of a cluster.
        cur = "R11";
        step(16'h0055);
        step(16'h0056);
        step(16'h0057);
        step(16'h0057, 1, 0);
        for (int i = 0; i < 12; i++) step(16'h0000);
        // R7: long quiet stretch forces a cluster with a wrapped timestamp.
        cur = "R7";
        step(16'h0C0C);
        for (int i = 0; i < 65545; i++) step(16'h0C0C);
        // R9 / R10: back-to-back clusters fill every row and wrap the position.
        cur = "R9";
        step(16'h0000, 1, 0);
        for (int i = 0; i < 2040; i++) step(DW'(i + 1));
        cur = "R10";
        for (int i = 2040; i < 2080; i++) step(DW'(i + 1));
        for (int i = 0; i < 4; i++) step(DW'(2080));
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule